// File: doc/BRIEF.md
# LIN Response Checksum Verifier

This block checks the checksum byte at the end of a LIN response. A start strobe opens a frame and presents the protected identifier (PID) together with a protocol-version select. Response bytes then arrive one per valid strobe, and the last one, which is the received checksum, is marked. The block keeps an 8-bit running sum in which every carry out of the top bit is added back into the low end. One cycle after the last byte it pulses a result flag with a pass/fail bit and the wrapped sum.

Two rules decide whether the PID takes part in the sum. Under the classic rule (version select low) only the data bytes and the checksum are summed. Under the enhanced rule (version select high) the whole PID byte, parity bits included, is added as well. The exception is a 6-bit identifier of 60 or 61, where the PID stays out even in enhanced mode. A frame passes when the wrapped sum is 0xFF. Frame capture, parity checking and checksum generation are done elsewhere.

Top module: `lin_cksum_check`

## Requirements
- R1: While reset is asserted and after its release, `res_vld_o`, `res_ok_o` and `res_sum_o` are all zero until a frame completes.
- R2: A byte accepted with `byte_last_i` high makes `res_vld_o` high in exactly the next cycle, and only for that one cycle.
- R3: `res_sum_o` equals the sum of all included bytes with carries out of bit 7 added back in. It is identical to folding the full-width total repeatedly down to 8 bits, and it is zero only when that total is zero.
- R4: `res_ok_o` is 1 exactly when the wrapped sum is 0xFF and 0 otherwise. It holds its value until the next result.
- R5: With `ver2_i` low at the start strobe, the PID is not part of the sum.
- R6: With `ver2_i` high at the start strobe and `pid_i[5:0]` neither 60 nor 61, all 8 PID bits, including parity bits 7:6, are part of the sum.
- R7: With `ver2_i` high and `pid_i[5:0]` equal to 60 or 61, the PID is left out whatever its bits 7:6 hold.
- R8: A start strobe in the middle of a frame discards the partial sum and begins a new frame.
- R9: A byte strobe while no frame is open is ignored. This covers bytes before the first start and bytes after a last byte. Such a byte produces no result and does not change the next frame's sum.
- R10: A byte strobe in the same cycle as a start strobe is ignored.
- R11: `pid_i` and `ver2_i` are sampled only at the start strobe. Changes to them during the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a frame and samples `pid_i` and `ver2_i` |
| pid_i | input | 8 | Protected identifier (ID in bits 5:0, parity in 7:6) |
| ver2_i | input | 1 | 1 = enhanced rule, 0 = classic rule |
| byte_vld_i | input | 1 | Response byte strobe |
| byte_i | input | 8 | Response byte |
| byte_last_i | input | 1 | Marks the received checksum byte |
| res_vld_o | output | 1 | One-cycle result pulse |
| res_ok_o | output | 1 | Checksum pass flag |
| res_sum_o | output | 8 | Wrapped sum of the frame |

## Verification
The hardest cases to reach from the ports are those where the PID rule must visibly make a difference. A frame that passes under one rule has to fail under the other, and a reserved identifier has to carry nonzero parity bits. To get there, the bench computes a checksum under a deliberately wrong inclusion choice and expects a fail. Another hard case is a start strobe landing inside a frame. The bench drives a half-sent frame, interrupts it with a new start, and expects the result to reflect only the second frame. Byte strobes that coincide with a start, or arrive outside any frame, are placed with bytes that would break the checksum if they were counted.

// File: rtl/lin_ck_pkg.sv
// Package lin_ck_pkg
// Shared widths, the byte type and the end-around-carry addition.
// Assumes a LIN byte of 8 bits and a 6-bit frame identifier.
package lin_ck_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ID_W   = 6;

    typedef logic [BYTE_W-1:0] byte_t;

    // Adds two bytes and feeds the carry back into bit 0.
    // The largest case is 0xFF + 0xFF = 0x1FE, which wraps to 0xFF, so a
    // single feedback step is always enough.
    function automatic byte_t wrap_add(byte_t a, byte_t b);
        logic [BYTE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BYTE_W-1:0] + byte_t'(s[BYTE_W]);
    endfunction

endpackage

// File: rtl/lin_ck_pid_rule.sv
// Module lin_ck_pid_rule
// Works out the accumulator preset for a new frame. The preset is the PID
// when the enhanced rule applies and the ID is not reserved, and zero
// otherwise. Purely combinational.
// Assumes EXCL_IDS packs NUM_EXCL identifiers of ID_W bits, entry 0 lowest.
module lin_ck_pid_rule
    import lin_ck_pkg::*;
#(
    parameter int unsigned               NUM_EXCL = 2,
    parameter logic [NUM_EXCL*ID_W-1:0]  EXCL_IDS = {6'd61, 6'd60}
) (
    input  byte_t pid,
    input  logic  ver2,
    output byte_t preset
);

    logic [NUM_EXCL-1:0] id_hit;

    // One comparator per reserved identifier.
    generate
        for (genvar g = 0; g < NUM_EXCL; g++) begin : g_excl
            assign id_hit[g] = (pid[ID_W-1:0] == EXCL_IDS[g*ID_W +: ID_W]);
        end
    endgenerate

    // Include the whole PID byte only in enhanced mode for unreserved IDs.
    always_comb begin
        preset = '0;
        if (ver2 && !(|id_hit)) begin
            preset = pid;
        end
    end

endmodule

// File: rtl/lin_ck_frame_ctl.sv
// Module lin_ck_frame_ctl
// Tracks whether a frame is open and decides which byte strobes count.
// A start opens a frame, even one already open. An accepted last byte
// closes it. Strobes in a start cycle or outside a frame are dropped.
module lin_ck_frame_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic byte_vld,
    input  logic byte_last,
    output logic frame_open,
    output logic accept,
    output logic accept_last
);

    // A byte counts only inside an open frame and never alongside a start.
    always_comb begin
        accept      = byte_vld && frame_open && !start;
        accept_last = accept && byte_last;
    end

    // Frame-open flag: set by start, cleared by the accepted last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_open <= 1'b0;
        end else if (start) begin
            frame_open <= 1'b1;
        end else if (accept_last) begin
            frame_open <= 1'b0;
        end
    end

endmodule

// File: rtl/lin_ck_accum.sv
// Module lin_ck_accum
// Holds the 8-bit running sum. A start loads the preset; each accepted byte
// is added with end-around carry. sum_nxt presents the value the sum takes
// with the current byte added, which the result stage needs.
module lin_ck_accum
    import lin_ck_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t preset,
    input  logic  add,
    input  byte_t data,
    output byte_t sum_nxt
);

    byte_t acc_q;

    // Sum with the incoming byte folded in.
    always_comb begin
        sum_nxt = wrap_add(acc_q, data);
    end

    // Accumulator register: a preset on load, otherwise an update per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= preset;
        end else if (add) begin
            acc_q <= sum_nxt;
        end
    end

endmodule

// File: rtl/lin_ck_result.sv
// Module lin_ck_result
// Registers the frame verdict. It pulses vld for one cycle after the last
// byte and holds sum and ok until the next verdict.
module lin_ck_result
    import lin_ck_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  done,
    input  byte_t final_sum,
    output logic  vld,
    output logic  ok,
    output byte_t sum
);

    localparam byte_t ALL_ONES = '1;

    // Result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
        end else begin
            vld <= done;
        end
    end

    // Verdict and sum, captured on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok  <= 1'b0;
            sum <= '0;
        end else if (done) begin
            ok  <= (final_sum == ALL_ONES);
            sum <= final_sum;
        end
    end

endmodule

// File: rtl/lin_cksum_check.sv
// Module lin_cksum_check (top)
// Verifies a LIN response checksum under the classic or enhanced rule.
// Assumes the upstream receiver marks the checksum byte with byte_last_i
// and gives start_i at least one cycle before the first data byte.
module lin_cksum_check
    import lin_ck_pkg::*;
#(
    parameter int unsigned               NUM_EXCL = 2,
    parameter logic [NUM_EXCL*ID_W-1:0]  EXCL_IDS = {6'd61, 6'd60}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] pid_i,
    input  logic              ver2_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_last_i,
    output logic              res_vld_o,
    output logic              res_ok_o,
    output logic [BYTE_W-1:0] res_sum_o
);

    byte_t preset;
    byte_t sum_nxt;
    logic  frame_open;
    logic  accept;
    logic  accept_last;

    lin_ck_pid_rule #(
        .NUM_EXCL (NUM_EXCL),
        .EXCL_IDS (EXCL_IDS)
    ) u_rule (
        .pid    (pid_i),
        .ver2   (ver2_i),
        .preset (preset)
    );

    lin_ck_frame_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_i),
        .byte_vld    (byte_vld_i),
        .byte_last   (byte_last_i),
        .frame_open  (frame_open),
        .accept      (accept),
        .accept_last (accept_last)
    );

    lin_ck_accum u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_i),
        .preset  (preset),
        .add     (accept),
        .data    (byte_i),
        .sum_nxt (sum_nxt)
    );

    lin_ck_result u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (accept_last),
        .final_sum (sum_nxt),
        .vld       (res_vld_o),
        .ok        (res_ok_o),
        .sum       (res_sum_o)
    );

endmodule

// File: rtl/lin_cksum_check_sva.sv
// Module lin_cksum_check_sva
// Checker bound to lin_cksum_check. It relates the byte strobes and the
// frame-open flag to the result outputs over time.
module lin_cksum_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       byte_vld_i,
    input logic       byte_last_i,
    input logic       frame_open,
    input logic       res_vld_o,
    input logic       res_ok_o,
    input logic [7:0] res_sum_o
);

    // R1: the cycle after a reset cycle shows idle outputs.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!res_vld_o && !res_ok_o && res_sum_o == 8'h00));

    // R2: an accepted last byte yields a pulse in the next cycle.
    a_r2_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && byte_last_i && frame_open && !start_i) |=> res_vld_o);

    // R2: the pulse lasts a single cycle.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |=> !res_vld_o);

    // R4: at a result, the pass flag agrees with the reported sum.
    a_r4_ok_matches_sum: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> (res_ok_o == (res_sum_o == 8'hFF)));

    // R9 and R10: a pulse only follows a byte accepted in an open frame.
    a_r9_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> $past(byte_vld_i && byte_last_i && frame_open && !start_i));

endmodule

bind lin_cksum_check lin_cksum_check_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_vld_i  (byte_vld_i),
    .byte_last_i (byte_last_i),
    .frame_open  (frame_open),
    .res_vld_o   (res_vld_o),
    .res_ok_o    (res_ok_o),
    .res_sum_o   (res_sum_o)
);

// File: tb/sim_lin_cksum_check.sv
// Bench for lin_cksum_check. A table of frames is walked by one loop, then
// directed tests cover reset and the corner cases.
module sim_lin_cksum_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] pid_i = 8'h00;
    logic       ver2_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       byte_last_i = 1'b0;
    logic       res_vld_o;
    logic       res_ok_o;
    logic [7:0] res_sum_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lin_cksum_check u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pid_i       (pid_i),
        .ver2_i      (ver2_i),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .byte_last_i (byte_last_i),
        .res_vld_o   (res_vld_o),
        .res_ok_o    (res_ok_o),
        .res_sum_o   (res_sum_o)
    );

    typedef struct packed {
        logic [7:0]  pid;
        logic        ver2;
        logic [3:0]  n;
        logic [63:0] d;
        logic        bad;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{pid: 8'h4A, ver2: 1'b1, n: 4'd2, d: 64'h0000_0000_0000_0201, bad: 1'b0},
        '{pid: 8'h4A, ver2: 1'b0, n: 4'd2, d: 64'h0000_0000_0000_0201, bad: 1'b0},
        '{pid: 8'h3C, ver2: 1'b1, n: 4'd8, d: 64'hFFFF_FFFF_FFFF_FFFF, bad: 1'b0},
        '{pid: 8'hFD, ver2: 1'b1, n: 4'd3, d: 64'h0000_0000_00A5_80F0, bad: 1'b0},
        '{pid: 8'hC1, ver2: 1'b1, n: 4'd8, d: 64'hFFFF_FFFF_FFFF_FFFF, bad: 1'b1},
        '{pid: 8'h00, ver2: 1'b0, n: 4'd1, d: 64'h0000_0000_0000_0000, bad: 1'b0},
        '{pid: 8'h7F, ver2: 1'b1, n: 4'd4, d: 64'h0000_0000_1234_5678, bad: 1'b1},
        '{pid: 8'h3D, ver2: 1'b0, n: 4'd8, d: 64'h8877_6655_4433_2211, bad: 1'b0}
    };

    // Reference: fold a wide total down to 8 bits.
    function automatic logic [7:0] ref_fold(int unsigned s);
        while (s > 255) s = (s & 255) + (s >> 8);
        return s[7:0];
    endfunction

    // Reference rule for PID inclusion.
    function automatic bit ref_incl(logic [7:0] pid, logic ver2);
        return ver2 && (pid[5:0] != 6'd60) && (pid[5:0] != 6'd61);
    endfunction

    // Sum of included PID and data bytes, before the checksum.
    function automatic int unsigned ref_total(bit incl, logic [7:0] pid, int n, logic [63:0] d);
        int unsigned s = incl ? pid : 0;
        for (int i = 0; i < n; i++) s += d[8*i +: 8];
        return s;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start(logic [7:0] pid, logic ver2);
        start_i = 1'b1; pid_i = pid; ver2_i = ver2;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_byte(logic [7:0] b, logic last);
        byte_vld_i = 1'b1; byte_i = b; byte_last_i = last;
        @(negedge clk);
        byte_vld_i = 1'b0; byte_last_i = 1'b0;
    endtask

    // Sends data plus checksum; returns at the cycle the result is visible.
    task automatic send_body(int n, logic [63:0] d, logic [7:0] ck);
        for (int i = 0; i < n; i++) do_byte(d[8*i +: 8], 1'b0);
        do_byte(ck, 1'b1);
    endtask

    // Checks a result pulse now and its end one cycle later.
    task automatic expect_res(string req, logic exp_ok, logic [7:0] exp_sum);
        chk({req, " vld"}, res_vld_o, 1'b1);
        chk({req, " ok"}, res_ok_o, exp_ok);
        chk({req, " sum"}, res_sum_o, exp_sum);
        @(negedge clk);
        chk("R2 pulse ends", res_vld_o, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ck;
        int unsigned s;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset and right after it.
        chk("R1 vld", res_vld_o, 1'b0);
        chk("R1 ok", res_ok_o, 1'b0);
        chk("R1 sum", res_sum_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vld after release", res_vld_o, 1'b0);

        // Table walk: R3, R4, R5, R6, R7 with correct or corrupted checksums.
        for (int k = 0; k < NV; k++) begin
            s  = ref_total(ref_incl(TBL[k].pid, TBL[k].ver2), TBL[k].pid, int'(TBL[k].n), TBL[k].d);
            ck = ~ref_fold(s);
            if (TBL[k].bad) ck = ck ^ 8'h01;
            do_start(TBL[k].pid, TBL[k].ver2);
            send_body(int'(TBL[k].n), TBL[k].d, ck);
            expect_res("R3 R4 R6 R7 table", !TBL[k].bad, ref_fold(s + ck));
        end

        // R5: classic mode, checksum built with PID included must fail.
        s  = ref_total(1'b1, 8'h4A, 2, 64'h0201);
        ck = ~ref_fold(s);
        do_start(8'h4A, 1'b0);
        send_body(2, 64'h0201, ck);
        expect_res("R5 pid excluded", 1'b0, ref_fold(ref_total(1'b0, 8'h4A, 2, 64'h0201) + ck));

        // R6: enhanced mode with ID 5 and parity bits set; classic checksum fails.
        s  = ref_total(1'b0, 8'hC5, 3, 64'h3_0201);
        ck = ~ref_fold(s);
        do_start(8'hC5, 1'b1);
        send_body(3, 64'h3_0201, ck);
        expect_res("R6 pid included", 1'b0, ref_fold(ref_total(1'b1, 8'hC5, 3, 64'h3_0201) + ck));

        // R7: ID 60 with parity bits set in enhanced mode; pid-included checksum fails.
        s  = ref_total(1'b1, 8'hFC, 2, 64'h1020);
        ck = ~ref_fold(s);
        do_start(8'hFC, 1'b1);
        send_body(2, 64'h1020, ck);
        expect_res("R7 reserved id", 1'b0, ref_fold(ref_total(1'b0, 8'hFC, 2, 64'h1020) + ck));

        // R8: a partial frame is cut off by a new start.
        do_start(8'h11, 1'b1);
        do_byte(8'h99, 1'b0);
        do_byte(8'h77, 1'b0);
        chk("R8 no pulse mid frame", res_vld_o, 1'b0);
        s  = ref_total(1'b1, 8'h22, 2, 64'h0403);
        ck = ~ref_fold(s);
        do_start(8'h22, 1'b1);
        send_body(2, 64'h0403, ck);
        expect_res("R8 restart", 1'b1, 8'hFF);

        // R9: a last byte with no open frame is ignored.
        do_byte(8'h5A, 1'b1);
        chk("R9 no pulse outside frame", res_vld_o, 1'b0);
        do_byte(8'h33, 1'b0);
        chk("R9 still no pulse", res_vld_o, 1'b0);
        s  = ref_total(1'b0, 8'h00, 1, 64'h40);
        ck = ~ref_fold(s);
        do_start(8'h00, 1'b0);
        send_body(1, 64'h40, ck);
        expect_res("R9 next frame clean", 1'b1, 8'hFF);

        // R10: a byte strobe alongside the start is dropped.
        s  = ref_total(1'b1, 8'h05, 2, 64'h0908);
        ck = ~ref_fold(s);
        byte_vld_i = 1'b1; byte_i = 8'h37;
        do_start(8'h05, 1'b1);
        byte_vld_i = 1'b0;
        send_body(2, 64'h0908, ck);
        expect_res("R10 start-cycle byte ignored", 1'b1, 8'hFF);

        // R11: PID and version changes inside a frame have no effect.
        s  = ref_total(1'b1, 8'h12, 2, 64'hA0B0);
        ck = ~ref_fold(s);
        do_start(8'h12, 1'b1);
        pid_i = 8'hEE; ver2_i = 1'b0;
        send_body(2, 64'hA0B0, ck);
        expect_res("R11 sampled at start", 1'b1, 8'hFF);

        // R1: reset mid-frame returns outputs to idle.
        do_start(8'h12, 1'b1);
        do_byte(8'h01, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 vld in reset", res_vld_o, 1'b0);
        chk("R1 ok in reset", res_ok_o, 1'b0);
        chk("R1 sum in reset", res_sum_o, 8'h00);
        rst_n = 1'b1;
        do_byte(8'hFE, 1'b1);
        chk("R9 no frame after reset", res_vld_o, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule